// File: doc/BRIEF.md
# Task Priority Interrupt Filter

This block keeps a 4-bit task priority and uses it to decide which external interrupt request may reach the processor. Requests arrive on a 15-line input, one line per priority class from 1 (lowest) to 15 (highest). A pulse on a line sets a sticky pending bit for that class. Each cycle the block picks the highest pending class. It presents that class, with a valid flag, only when the class is strictly above the task priority. An acknowledge taken while the flag is up clears the pending bit of the class being shown.

Software sets the priority through a 64-bit register port. A write is accepted only when the supervisor qualifier is high and bits 63:4 of the write data are all zero. Any other write leaves the register as it was and raises a one-cycle fault pulse. Reads return the priority zero-extended to 64 bits. Loading 0 lets every class through and loading 15 blocks every class.

Top module: `irq_prio_gate`

## Requirements
- R1: After reset the priority is 0, no class is pending, `irq_valid` and `irq_fault` are low and `irq_class` is 0.
- R2: A write with `reg_priv` high and `reg_wdata[63:4]` zero loads `reg_wdata[3:0]` into the priority. `reg_rdata` always shows the priority in bits 3:0, with bits 63:4 zero.
- R3: A write with any nonzero bit in `reg_wdata[63:4]` leaves the priority unchanged and drives `irq_fault` high for exactly the cycle after the write edge.
- R4: A write with `reg_priv` low leaves the priority unchanged and raises the same one-cycle `irq_fault` pulse.
- R5: `req_in[i]` high at a clock edge sets the pending bit of class i+1. The bit stays set until it is acknowledged.
- R6: When more than one class is pending, `irq_class` shows the highest-numbered one. `irq_class` reads 0 whenever `irq_valid` is low.
- R7: `irq_valid` is high only when the highest pending class is strictly greater than the priority. A priority of 0 passes class 1, and a priority of 15 blocks class 15.
- R8: The outputs are registered and reflect the state after the clock edge that applies a write, a request or an acknowledge. A new priority therefore takes effect in the cycle after the write.
- R9: `irq_ack` high while `irq_valid` is high clears the pending bit of the shown class on that edge. A request on the same class in the same cycle wins and keeps the bit set. `irq_ack` while `irq_valid` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_priv | input | 1 | Supervisor qualifier for writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Priority, zero-extended |
| req_in | input | 15 | Request lines; bit i is class i+1 |
| irq_ack | input | 1 | Acknowledge of the shown class |
| irq_valid | output | 1 | A class above the priority is shown |
| irq_class | output | 4 | Class shown (0 when not valid) |
| irq_fault | output | 1 | One-cycle pulse after a rejected write |

## Verification
Some properties are checked on every cycle by the assertions:
- a shown class is always above the current priority;
- no higher class is left pending behind the one shown;
- a rejected write never moves the priority and always produces a fault;
- an acknowledged class is gone on the next cycle unless it was requested again.

Other behaviour is shown only by the bench scenarios, because it needs a sequence of stimulus and a model of the state:
- the exact thresholds at priorities 0, 9 and 15;
- the one-cycle timing of a new priority;
- the outcome of long random mixes of writes, requests and acknowledges.

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
  parameter int DATA_W = 64,
  parameter int PRIO_W = 4,
  localparam int NCLS = (1 << PRIO_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_priv,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCLS-1:0]   req_in,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [PRIO_W-1:0] irq_class,
  output logic              irq_fault
);

  logic [PRIO_W-1:0] prio_q, prio_d, top_d;
  logic [NCLS-1:0]   pend_q, pend_d, clr;
  logic              bad_wr, valid_d;

  assign bad_wr    = reg_wr && (!reg_priv || (|reg_wdata[DATA_W-1:PRIO_W]));
  assign reg_rdata = {{(DATA_W-PRIO_W){1'b0}}, prio_q};

  always_comb begin
    prio_d = prio_q;
    if (reg_wr && !bad_wr) prio_d = reg_wdata[PRIO_W-1:0];
    clr = '0;
    if (irq_ack && irq_valid) clr[irq_class - PRIO_W'(1)] = 1'b1;
    pend_d = (pend_q & ~clr) | req_in;
    top_d = '0;
    for (int i = 0; i < NCLS; i++)
      if (pend_d[i]) top_d = PRIO_W'(i + 1);
  end

  assign valid_d = top_d > prio_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q    <= '0;
      pend_q    <= '0;
      irq_valid <= 1'b0;
      irq_class <= '0;
      irq_fault <= 1'b0;
    end else begin
      prio_q    <= prio_d;
      pend_q    <= pend_d;
      irq_valid <= valid_d;
      irq_class <= valid_d ? top_d : '0;
      irq_fault <= bad_wr;
    end
  end

  // R7
  above_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_class > prio_q);

  // R6
  highest_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend_q >> irq_class) == '0);

  // R3
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> (prio_q == $past(prio_q)) && irq_fault);

  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fault |-> $past(reg_wr) && (!$past(reg_priv) || ($past(reg_wdata) >> PRIO_W) != '0));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !req_in[irq_class - PRIO_W'(1)])
      |=> !pend_q[$past(irq_class) - PRIO_W'(1)]);

endmodule

// File: tb/irq_prio_gate_test.sv
module irq_prio_gate_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_priv = 0, irq_ack = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic [14:0] req_in = 0;
  logic        irq_valid, irq_fault;
  logic [3:0]  irq_class;

  int tests = 0, fails = 0;
  logic [3:0]  m_prio;
  logic [14:0] m_pend;
  logic        m_fault;
  bit          done = 0;

  irq_prio_gate uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_class(irq_class), .irq_fault(irq_fault));

  always #2 clk = ~clk;

  function automatic logic [3:0] top_of(logic [14:0] p);
    for (int i = 14; i >= 0; i--) if (p[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  function automatic logic [3:0] exp_class();
    return (top_of(m_pend) > m_prio) ? top_of(m_pend) : 4'd0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " rdata"}, reg_rdata, {60'd0, m_prio});
    chk({tag, " valid"}, 64'(irq_valid), 64'(exp_class() != 0));
    chk({tag, " class"}, 64'(irq_class), 64'(exp_class()));
    chk({tag, " fault"}, 64'(irq_fault), 64'(m_fault));
  endtask

  task automatic step(logic wr, logic priv, logic [63:0] wd, logic [14:0] rq, logic ak);
    logic bad;
    logic [3:0] c;
    @(negedge clk);
    reg_wr = wr; reg_priv = priv; reg_wdata = wd; req_in = rq; irq_ack = ak;
    bad = wr && (!priv || wd[63:4] != 0);
    c = exp_class();
    if (wr && !bad) m_prio = wd[3:0];
    if (ak && c != 0) m_pend[c-1] = 1'b0;
    m_pend |= rq;
    m_fault = bad;
    @(posedge clk); #1;
    reg_wr = 0; irq_ack = 0; req_in = 0;
  endtask

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_prio = 0; m_pend = 0; m_fault = 0;
    void'($urandom(32'h1b2c3d));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk); rst_n = 1;

    step(1, 1, 64'd9, 0, 0);          check_all("R2 write 9");
    step(0, 0, 0, 15'h0100, 0);       check_all("R7 class 9 at prio 9 blocked");
    step(0, 0, 0, 15'h0200, 0);       check_all("R7 class 10 at prio 9 passes");
    chk("R6 class10", 64'(irq_class), 64'd10);
    step(0, 0, 0, 15'h4001, 0);       check_all("R6 highest is 15");
    step(0, 0, 0, 0, 1);              check_all("R9 ack clears 15");
    chk("R9 next shown", 64'(irq_class), 64'd10);
    step(0, 0, 0, 15'h0200, 1);       check_all("R9 request wins over ack");
    step(1, 1, 64'h10, 0, 0);         check_all("R3 reserved bit rejected");
    chk("R3 fault high", 64'(irq_fault), 64'd1);
    step(0, 0, 0, 0, 0);              check_all("R3 fault one cycle");
    step(1, 0, 64'd0, 0, 0);          check_all("R4 unprivileged rejected");
    step(1, 1, 64'd15, 0, 0);         check_all("R8 prio 15 blocks next cycle");
    chk("R7 prio15 none", 64'(irq_valid), 64'd0);
    step(0, 0, 0, 0, 1);              check_all("R9 ack while invalid ignored");
    step(1, 1, 64'd0, 0, 0);          check_all("R8 prio 0 opens next cycle");
    chk("R7 prio0 class10", 64'(irq_class), 64'd10);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);              check_all("R5 drained");
    step(0, 0, 0, 15'h0001, 0);       check_all("R7 class 1 at prio 0");

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] wd;
      wd = {60'd0, 4'($urandom)};
      if ($urandom % 4 == 0) wd[4 + $urandom % 60] = 1'b1;
      step(($urandom % 5) == 0, ($urandom % 4) != 0, wd,
           ($urandom % 3 == 0) ? 15'(1 << ($urandom % 15)) : 15'd0,
           ($urandom % 2) == 0);
      check_all("R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule